// File: doc/BRIEF.md
# UART Receive Holding Buffer with Line-Error Tags

This block sits between a serial-to-parallel UART receiver and the host read path. Each time the receiver finishes a character, it writes the data byte and that character's 3-bit line-error tag into the buffer. The host takes characters from a read port that shows the oldest entry with its tag in the same cycle. The block also reports how full it is and whether the fill level has reached a level the host selected.

Two modes are available. In queue mode the buffer holds up to 128 characters in arrival order. In holding mode only entry 0 is used, so the block acts as a one-character holding register. A character that arrives while the buffer is full is lost, and a sticky overrun flag records the loss. A clear strobe, or any change of the mode bit, empties the buffer. The count, the data-available flag, the trigger flag and the overrun flag give the interrupt logic outside the block what it needs.

Top module: `urx_rx_buffer`

## Requirements
- R1: After a synchronous active-low reset, `fill_count` is 0 and `data_ready`, `trig_hit` and `overrun` are all 0.
- R2: Characters leave through the read port in the order they were accepted. Each `rd_data` byte appears in the same cycle as its own `rd_err` tag, which is coded bit 0 = parity error, bit 1 = framing error, bit 2 = break.
- R3: With `fifo_en` = 1 the buffer holds 128 characters. A push at a count of 128 is dropped, the count stays at 128, and the stored contents are unchanged.
- R4: A dropped push sets `overrun` on the following cycle. `overrun` then stays high until a cycle with `ovr_ack` = 1 and no new drop, or until a flush.
- R5: With `fifo_en` = 0 the buffer holds one character. A second push before that character is read is dropped, sets `overrun`, and leaves the first character readable.
- R6: A cycle with `rx_clear` = 1 flushes the buffer: `fill_count` becomes 0 and `overrun` becomes 0 on the next cycle. A push in that same cycle is discarded and does not set `overrun`.
- R7: `trig_hit` is 1 exactly when `fill_count` is at or above the level picked by `trig_sel`: 00 selects 1, 01 selects 4, 10 selects 120 and 11 selects 124.
- R8: A change of `fifo_en` in either direction flushes the buffer in the same way as `rx_clear`.
- R9: `data_ready` equals (`fill_count` != 0). An `rd_en` while the buffer is empty has no effect.
- R10: A push and a read in the same cycle, on a buffer that is neither empty nor full, leave `fill_count` unchanged and keep the order of the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = 128-entry queue mode, 0 = single holding entry |
| rx_clear | input | 1 | One-cycle flush strobe |
| trig_sel | input | 2 | Fill trigger select (1/4/120/124 characters) |
| ovr_ack | input | 1 | Clears the sticky overrun flag |
| push_valid | input | 1 | Receiver has a completed character |
| push_data | input | 8 | Received byte |
| push_err | input | 3 | Error tag {break, framing, parity} |
| rd_en | input | 1 | Host takes the head entry |
| rd_data | output | 8 | Byte at the head of the buffer |
| rd_err | output | 3 | Error tag of the head byte |
| fill_count | output | 8 | Number of stored characters |
| data_ready | output | 1 | At least one character is stored |
| trig_hit | output | 1 | Count is at or above the selected level |
| overrun | output | 1 | Sticky flag for a lost character |

## Verification
The assertions watch a set of rules on every cycle. The count never goes above the capacity of the active mode. A flush always leaves the buffer empty with `overrun` cleared. `overrun` stays set until it is acknowledged or flushed. A simultaneous push and read leaves the count unchanged. Other behaviour needs the bench's scenarios to be seen: that bytes come out in order with the correct tag, that the head entry survives an overflow, where the four trigger thresholds fall, and how the block behaves in holding mode after a mode change. The bench checks these against a queue model.

// File: rtl/urx_pkg.sv
// Package: shared widths and the stored-entry type for the receive buffer.
// Assumes an 8-bit character and a 3-bit error tag {break, framing, parity}.
package urx_pkg;
    localparam int URX_DATA_W = 8;
    localparam int URX_ERR_W  = 3;
    localparam int URX_ERR_PARITY  = 0;
    localparam int URX_ERR_FRAMING = 1;
    localparam int URX_ERR_BREAK   = 2;

    typedef struct packed {
        logic [URX_ERR_W-1:0]  err;
        logic [URX_DATA_W-1:0] data;
    } urx_entry_t;
endpackage

// File: rtl/urx_store.sv
// Module: entry storage for the receive buffer.
// One write port and one read port that reads without a clock, so the head
// entry is visible in the same cycle it becomes valid. The storage has no
// reset: a valid count decides which entries mean anything.
module urx_store
    import urx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  urx_entry_t    wr_entry,
    input  logic [AW-1:0] rd_addr,
    output urx_entry_t    rd_entry
);
    urx_entry_t mem [DEPTH];

    // Write the accepted character into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_entry;
    end

    // Present the head entry without waiting for a clock.
    always_comb rd_entry = mem[rd_addr];
endmodule

// File: rtl/urx_ptr_ctrl.sv
// Module: pointer, count and overrun control for the receive buffer.
// Assumes the caller holds fifo_en at a stable level and uses rx_clear as a
// one-cycle strobe. A change of fifo_en is seen one cycle after it happens
// and flushes the buffer. Holding mode sets the capacity to 1 and pins both
// pointers to entry 0.
module urx_ptr_ctrl #(
    parameter int DEPTH = 128,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          rx_clear,
    input  logic          ovr_ack,
    input  logic          push,
    input  logic          pop,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count,
    output logic          overrun
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic          en_q;
    logic          mode_chg;
    logic          flush;
    logic [CW-1:0] cap;
    logic          full;
    logic          wr_ok;
    logic          rd_ok;
    logic          drop;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Decode flush, capacity and whether this cycle's push and read are accepted.
    always_comb begin
        mode_chg = fifo_en ^ en_q;
        flush    = rx_clear | mode_chg;
        cap      = fifo_en ? CW'(DEPTH) : CW'(1);
        full     = (count >= cap);
        wr_ok    = push & ~full & ~flush;
        rd_ok    = pop & (count != '0) & ~flush;
        drop     = push & full & ~flush;
    end

    // Remember the mode bit so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= fifo_en;
        else        en_q <= fifo_en;
    end

    // Advance the write pointer, wrapping at the last slot or pinned to 0.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)   wr_ptr <= '0;
        else if (wr_ok)        wr_ptr <= (!fifo_en || wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
    end

    // Advance the read pointer in the same way as the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)   rd_ptr <= '0;
        else if (rd_ok)        rd_ptr <= (!fifo_en || rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
    end

    // Track the number of stored characters.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) count <= '0;
        else begin
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Sticky overrun: a drop sets it and wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) overrun <= 1'b0;
        else if (drop)       overrun <= 1'b1;
        else if (ovr_ack)    overrun <= 1'b0;
    end

    always_comb begin
        wr_en   = wr_ok;
        wr_addr = wr_ptr;
        rd_addr = rd_ptr;
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r5_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !mode_chg) |-> count <= CW'(1));

    a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !overrun));

    a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_ack && !flush) |=> overrun);

    a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> $stable(count));
endmodule

// File: rtl/urx_trig.sv
// Module: fill-level trigger for the receive buffer.
// Compares the stored count with one of four threshold parameters, chosen
// by a 2-bit select. Purely combinational.
module urx_trig #(
    parameter int CW   = 8,
    parameter int LVL0 = 1,
    parameter int LVL1 = 4,
    parameter int LVL2 = 120,
    parameter int LVL3 = 124
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    sel,
    output logic          hit
);
    logic [CW-1:0] level;

    // Pick the threshold and compare the count against it.
    always_comb begin
        case (sel)
            2'b00:   level = CW'(LVL0);
            2'b01:   level = CW'(LVL1);
            2'b10:   level = CW'(LVL2);
            default: level = CW'(LVL3);
        endcase
        hit = (count >= level);
    end
endmodule

// File: rtl/urx_rx_buffer.sv
// Module: UART receive holding buffer with per-character line-error tags.
// Joins the storage, the pointer control and the trigger. Assumes the
// receiver pushes at most one character per cycle and that the host reads the
// head with rd_en while looking at rd_data and rd_err in that same cycle.
module urx_rx_buffer
    import urx_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int LVL0  = 1,
    parameter int LVL1  = 4,
    parameter int LVL2  = 120,
    parameter int LVL3  = 124,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_en,
    input  logic                  rx_clear,
    input  logic [1:0]            trig_sel,
    input  logic                  ovr_ack,
    input  logic                  push_valid,
    input  logic [URX_DATA_W-1:0] push_data,
    input  logic [URX_ERR_W-1:0]  push_err,
    input  logic                  rd_en,
    output logic [URX_DATA_W-1:0] rd_data,
    output logic [URX_ERR_W-1:0]  rd_err,
    output logic [CW-1:0]         fill_count,
    output logic                  data_ready,
    output logic                  trig_hit,
    output logic                  overrun
);
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    urx_entry_t    wr_entry;
    urx_entry_t    rd_entry;

    // Pack the incoming byte with its tag and unpack the head entry.
    always_comb begin
        wr_entry.data = push_data;
        wr_entry.err  = push_err;
        rd_data       = rd_entry.data;
        rd_err        = rd_entry.err;
        data_ready    = (fill_count != '0);
    end

    urx_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .rx_clear (rx_clear),
        .ovr_ack  (ovr_ack),
        .push     (push_valid),
        .pop      (rd_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .count    (fill_count),
        .overrun  (overrun)
    );

    urx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_entry (wr_entry),
        .rd_addr  (rd_addr),
        .rd_entry (rd_entry)
    );

    urx_trig #(.CW(CW), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) u_trig (
        .count (fill_count),
        .sel   (trig_sel),
        .hit   (trig_hit)
    );

    a_r9_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready && !push_valid) |=> !data_ready);
endmodule

// File: tb/urx_rx_buffer_tb.sv
`timescale 1ns/1ps
module urx_rx_buffer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rx_clear = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic       ovr_ack = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic [2:0] push_err = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic [7:0] fill_count;
    logic       data_ready;
    logic       trig_hit;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    logic [10:0] sb_q[$];
    int  m_cnt = 0;
    bit  m_ovr = 0;
    bit  pop_expect = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    urx_rx_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_clear(rx_clear),
        .trig_sel(trig_sel), .ovr_ack(ovr_ack), .push_valid(push_valid),
        .push_data(push_data), .push_err(push_err), .rd_en(rd_en),
        .rd_data(rd_data), .rd_err(rd_err), .fill_count(fill_count),
        .data_ready(data_ready), .trig_hit(trig_hit), .overrun(overrun)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int level(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 120;
            default: return 124;
        endcase
    endfunction

    // Monitor: when a read is expected to take the head, compare it with the scoreboard (R2).
    always @(negedge clk) begin
        if (rst_n && rd_en && pop_expect) begin
            check("R2 head byte", int'(rd_data), int'(sb_q[0][7:0]));
            check("R2 head tag", int'(rd_err), int'(sb_q[0][10:8]));
            void'(sb_q.pop_front());
        end
    end

    // Driver: one stimulus cycle, with the model updated for the edge it meets.
    task automatic step(input bit p, input logic [7:0] d, input logic [2:0] e,
                        input bit r, input bit clr, input bit ack);
        int cap;
        bit acc;
        @(posedge clk); #1;
        push_valid = p; push_data = d; push_err = e;
        rd_en = r; rx_clear = clr; ovr_ack = ack;
        cap = fifo_en ? 128 : 1;
        pop_expect = r && (m_cnt > 0) && !clr;
        if (clr) begin
            sb_q.delete(); m_cnt = 0; m_ovr = 0;
        end else begin
            acc = p && (m_cnt < cap);
            if (pop_expect) m_cnt--;
            if (acc) begin sb_q.push_back({e, d}); m_cnt++; end
            if (p && !acc) m_ovr = 1;
            else if (ack) m_ovr = 0;
        end
        @(posedge clk); #1;
        push_valid = 0; rd_en = 0; rx_clear = 0; ovr_ack = 0; pop_expect = 0;
    endtask

    task automatic set_en(input bit v);
        @(posedge clk); #1;
        if (v != fifo_en) begin sb_q.delete(); m_cnt = 0; m_ovr = 0; end
        fifo_en = v;
        @(posedge clk); #1;
    endtask

    task automatic status(input string tag);
        @(negedge clk);
        check({tag, " count"}, int'(fill_count), m_cnt);
        check({tag, " R9 ready"}, int'(data_ready), int'(m_cnt != 0));
        check({tag, " R7 trigger"}, int'(trig_hit), int'(m_cnt >= level(trig_sel)));
        check({tag, " R4 overrun"}, int'(overrun), int'(m_ovr));
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        status("R1 reset");

        // R2/R7: small queue with mixed tags, trigger at 4.
        trig_sel = 2'b01;
        step(1, 8'h41, 3'b001, 0, 0, 0);
        step(1, 8'h42, 3'b010, 0, 0, 0);
        step(1, 8'h43, 3'b100, 0, 0, 0);
        status("R7 three below four");
        step(1, 8'h44, 3'b000, 0, 0, 0);
        status("R7 four reached");
        // R10: push and read together.
        step(1, 8'h45, 3'b011, 1, 0, 0);
        status("R10 push+read");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0);
        status("R2 drained");
        // R9: read on empty.
        step(0, 0, 0, 1, 0, 0);
        status("R9 empty read");

        // R3/R7: fill to capacity.
        trig_sel = 2'b10;
        for (int i = 0; i < 119; i++) step(1, 8'(i), 3'(i % 8), 0, 0, 0);
        status("R7 119 of 120");
        step(1, 8'd119, 3'd7, 0, 0, 0);
        status("R7 120 reached");
        trig_sel = 2'b11;
        for (int i = 120; i < 123; i++) step(1, 8'(i), 3'(i % 8), 0, 0, 0);
        status("R7 123 of 124");
        step(1, 8'd123, 3'd3, 0, 0, 0);
        status("R7 124 reached");
        for (int i = 124; i < 128; i++) step(1, 8'(i), 3'(i % 8), 0, 0, 0);
        status("R3 full");
        step(1, 8'hEE, 3'd7, 0, 0, 0);
        status("R3 drop on full");
        step(0, 0, 0, 0, 0, 0);
        status("R4 overrun held");
        step(0, 0, 0, 1, 0, 0);
        status("R3 head kept after drop");
        step(0, 0, 0, 0, 0, 1);
        status("R4 ack");
        for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 0, 0);
        status("R2 partial drain");
        step(1, 8'h55, 3'd1, 0, 1, 0);
        status("R6 clear with push");

        // R8: mode change flushes.
        for (int i = 0; i < 3; i++) step(1, 8'(8'h60 + i), 3'd0, 0, 0, 0);
        status("R8 before change");
        set_en(0);
        status("R8 disabled flush");
        // R5: holding mode.
        trig_sel = 2'b00;
        step(1, 8'hA5, 3'b110, 0, 0, 0);
        status("R5 one held");
        step(1, 8'h5A, 3'b001, 0, 0, 0);
        status("R5 second dropped");
        step(0, 0, 0, 1, 0, 0);
        status("R5 read held");
        step(1, 8'h77, 3'b101, 0, 0, 0);
        step(0, 0, 0, 1, 0, 1);
        status("R5 reuse entry");
        step(1, 8'h12, 3'b000, 0, 0, 0);
        set_en(1);
        status("R8 enable flush");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule